// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Three-Entry Character Queue

This block is the receive half of one serial channel. It watches a single line for start-stop framed characters. It paces itself from a clock-enable input, and a programmable multiple of that enable makes up one bit time. Each character is 5 to 8 bits long, with an optional parity bit and one or two stop bits. The block checks parity and stop-bit framing. It then places the character, with its own parity and framing flags, into a queue that holds three characters.

Two configuration bytes set the block up. The line byte holds the receiver enable, the character length and an option that allows reception only while carrier detect is asserted. The format byte holds the bit-time multiple, the stop-bit count and the parity selection. Software reads a status byte, an error byte and the head character of the queue. A read strobe removes that head character, and the head flags move forward with it. An error-reset strobe clears the sticky overrun and break indications.

Top module: `async_rx3`

## Requirements
- R1: After reset, `status`, `errors` and `rx_data` are all zero, and both configuration bytes are zero, so the receiver is disabled.
- R2: Line byte bit 0 enables the receiver. With it clear, no character is received. When line byte bit 5 is set, reception also needs `dcd` high. With `dcd` low, no character is received.
- R3: Line byte bits 7:6 set the character length: 00 = 5 bits, 01 = 7 bits, 10 = 6 bits, 11 = 8 bits. Data arrives least significant bit first. `rx_data` holds the character right-justified, with unused upper bits zero.
- R4: Format byte bits 7:6 set N, the number of `sample_en` pulses per bit: 00 = 1, 01 = 16, 10 = 32, 11 = 64. A start is detected on the first pulse that sees the line low. Later bits are sampled every N pulses after the start-bit centre. For N = 1, the detection pulse is itself the start-bit centre.
- R5: For N greater than 1, the line is checked again at pulse N/2 after detection. If it is high at that point, the start is discarded and no character is produced.
- R6: Format byte bit 0 enables a parity bit after the data, and bit 1 selects even parity (1) or odd parity (0). A mismatch sets `errors` bit 4 for that character.
- R7: Format byte bits 3:2 set the stop bits: 11 = two stop bits, each checked. Any other value checks one stop bit. A low stop sample sets `errors` bit 6 for that character.
- R8: The queue holds up to 3 characters. `status` bit 0 is 1 while the queue is not empty. `rx_data` shows the head character, and shows zero when the queue is empty. `data_rd` removes the head character. A read on an empty queue has no effect.
- R9: `errors` bits 4 and 6 belong to the head character, and they change to the next character's flags on each read.
- R10: A character that arrives while the queue is full replaces the newest entry and sets `errors` bit 5. That bit stays set through reads until `err_reset`.
- R11: A character whose data, parity and final stop samples are all low sets `status` bit 7. That bit stays set until `err_reset`. The character is still stored, with its framing flag set. After a low stop sample, the receiver waits for the line to go high before it looks for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sampling pulse; N pulses make one bit time |
| rxd | input | 1 | Serial input line, idle high |
| dcd | input | 1 | Carrier detect, active high |
| cfg_wr | input | 1 | Load the line byte |
| cfg_byte | input | 8 | Line byte: [7:6] length, [5] carrier gating, [0] enable |
| mode_wr | input | 1 | Load the format byte |
| mode_byte | input | 8 | Format byte: [7:6] multiple, [3:2] stop bits, [1] even, [0] parity on |
| data_rd | input | 1 | Remove the head character |
| err_reset | input | 1 | Clear the sticky overrun and break flags |
| rx_data | output | 8 | Head character, or zero when the queue is empty |
| status | output | 8 | [7] break seen, [0] queue not empty, other bits zero |
| errors | output | 8 | [6] framing, [5] overrun, [4] parity, other bits zero |

## Verification
The assertions assume that `rxd` and `dcd` are already synchronous to `clk`. They also assume that the configuration bytes are not rewritten while a character is being received, and that `err_reset` is not pulsed in the same cycle that a character is stored. The stimulus meets these conditions. It changes `rxd` only on the falling clock edge that also raises a `sample_en` pulse, so every bit lasts exactly N pulses, including for N = 1. It writes configuration, reads the queue and clears errors only while the line is idle between characters.

// File: rtl/async_rx3.sv
module async_rx3 #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       rxd,
  input  logic       dcd,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_byte,
  input  logic       mode_wr,
  input  logic [7:0] mode_byte,
  input  logic       data_rd,
  input  logic       err_reset,
  output logic [7:0] rx_data,
  output logic [7:0] status,
  output logic [7:0] errors
);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, HOLD} st_t;

  logic [7:0] cfg_q, mode_q;
  st_t        state;
  logic [5:0] cnt;
  logic [2:0] bitcnt;
  logic [7:0] shr;
  logic       par_bit, stop2, fe_acc;
  logic [6:0] div;
  logic [2:0] nlast;
  logic [9:0] mem [DEPTH];
  logic [CW-1:0] count, after, wr_idx;
  logic       ovr, brk;

  always_comb begin
    case (mode_q[7:6])
      2'b00:   div = 7'd1;
      2'b01:   div = 7'd16;
      2'b10:   div = 7'd32;
      default: div = 7'd64;
    endcase
    case (cfg_q[7:6])
      2'b00:   nlast = 3'd4;
      2'b01:   nlast = 3'd6;
      2'b10:   nlast = 3'd5;
      default: nlast = 3'd7;
    endcase
  end

  wire active   = cfg_q[0] & (~cfg_q[5] | dcd);
  wire tick     = sample_en & active;
  wire samp     = tick && ({1'b0, cnt} == div - 7'd1);
  wire mid      = tick && ({1'b0, cnt} == (div >> 1) - 7'd1);
  wire two_stop = mode_q[3:2] == 2'b11;
  wire push     = (state == STOP) && samp && (stop2 || !two_stop);
  wire fe_new   = fe_acc | ~rxd;
  wire pe_new   = mode_q[0] & ((^shr ^ par_bit) == mode_q[1]);
  wire brk_new  = fe_new && (shr == 8'd0) && !(mode_q[0] && par_bit) && !rxd;
  wire pop      = data_rd && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cfg_wr)  cfg_q  <= cfg_byte;
      if (mode_wr) mode_q <= mode_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; cnt <= '0; bitcnt <= '0; shr <= '0;
      par_bit <= 1'b0; stop2 <= 1'b0; fe_acc <= 1'b0;
    end else if (!active) begin
      state <= IDLE;
    end else if (tick) begin
      case (state)
        IDLE: if (!rxd) begin
          cnt <= '0; bitcnt <= '0; shr <= '0;
          state <= (div == 7'd1) ? DATA : START;
        end
        START: if (mid) begin
          cnt <= '0;
          state <= rxd ? IDLE : DATA;
        end else cnt <= cnt + 6'd1;
        DATA: if (samp) begin
          cnt <= '0;
          shr[bitcnt] <= rxd;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == nlast) begin
            state <= mode_q[0] ? PAR : STOP;
            stop2 <= 1'b0; fe_acc <= 1'b0;
          end
        end else cnt <= cnt + 6'd1;
        PAR: if (samp) begin
          cnt <= '0; par_bit <= rxd; state <= STOP;
        end else cnt <= cnt + 6'd1;
        STOP: if (samp) begin
          cnt <= '0;
          if (push) state <= rxd ? IDLE : HOLD;
          else begin stop2 <= 1'b1; fe_acc <= ~rxd; end
        end else cnt <= cnt + 6'd1;
        default: if (rxd) state <= IDLE;
      endcase
    end
  end

  assign after  = count - CW'(pop);
  assign wr_idx = (after == CW'(DEPTH)) ? CW'(DEPTH - 1) : after;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      count <= '0; ovr <= 1'b0; brk <= 1'b0;
    end else begin
      if (pop)
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i + 1];
      if (err_reset) begin ovr <= 1'b0; brk <= 1'b0; end
      if (push) begin
        mem[wr_idx] <= {pe_new, fe_new, shr};
        if (after == CW'(DEPTH)) ovr <= 1'b1;
        if (brk_new) brk <= 1'b1;
      end
      count <= after + CW'(push && (after != CW'(DEPTH)));
    end
  end

  wire nonempty = count != '0;
  assign rx_data = nonempty ? mem[0][7:0] : 8'd0;
  assign status  = {brk, 6'd0, nonempty};
  assign errors  = {1'b0, nonempty & mem[0][8], ovr, nonempty & mem[0][9], 4'd0};
endmodule

module async_rx3_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_reset,
  input logic          data_rd,
  input logic          push,
  input logic [CW-1:0] fcount,
  input logic [7:0]    status,
  input logic [7:0]    errors,
  input logic          rx_en
);
  assert_rx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(status[0]));
  assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && status[0] && !push) |=> fcount == CW'($past(fcount) - 1'b1));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !status[0] && !push) |=> !status[0]);
  assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errors[5]) |-> $past(push));
  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset && !push) |=> !errors[5]);
  assert_brk_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset && !push) |=> !status[7]);
endmodule

bind async_rx3 async_rx3_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_reset(err_reset), .data_rd(data_rd),
  .push(push), .fcount(count), .status(status), .errors(errors),
  .rx_en(cfg_q[0])
);

// File: tb/async_rx3_bench.sv
module async_rx3_bench;
  logic clk = 0, rst_n = 0, sample_en = 0, rxd = 1, dcd = 0;
  logic cfg_wr = 0, mode_wr = 0, data_rd = 0, err_reset = 0;
  logic [7:0] cfg_byte = 0, mode_byte = 0;
  logic [7:0] rx_data, status, err_byte;

  async_rx3 u_async_rx3 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd), .dcd(dcd),
    .cfg_wr(cfg_wr), .cfg_byte(cfg_byte), .mode_wr(mode_wr), .mode_byte(mode_byte),
    .data_rd(data_rd), .err_reset(err_reset),
    .rx_data(rx_data), .status(status), .errors(err_byte)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0, cmp_en = 0;
  logic [9:0] mq[$];
  bit m_ovr = 0, m_brk = 0;
  int cur_n = 5, cur_div = 1, cur_stop = 1;
  bit cur_pen = 0, cur_even = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_en) begin
      logic [7:0] es, ee, ed;
      es = {m_brk, 6'd0, mq.size() != 0};
      ed = (mq.size() != 0) ? mq[0][7:0] : 8'd0;
      ee = {1'b0, (mq.size() != 0) && mq[0][8], m_ovr, (mq.size() != 0) && mq[0][9], 4'd0};
      chk("R8 model status", status, es);
      chk("R9 model errors", err_byte, ee);
      chk("R3 model data", rx_data, ed);
    end
  end

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_byte = v; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    case (v[7:6]) 2'b00: cur_n = 5; 2'b01: cur_n = 7; 2'b10: cur_n = 6; default: cur_n = 8; endcase
  endtask

  task automatic wr_mode(logic [7:0] v);
    @(negedge clk); mode_byte = v; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
    case (v[7:6]) 2'b00: cur_div = 1; 2'b01: cur_div = 16; 2'b10: cur_div = 32; default: cur_div = 64; endcase
    cur_stop = (v[3:2] == 2'b11) ? 2 : 1;
    cur_pen = v[0]; cur_even = v[1];
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); sample_en = 1;
      @(negedge clk); sample_en = 0;
    end
  endtask

  task automatic bitx(logic v);
    @(negedge clk); rxd = v; sample_en = 1;
    @(negedge clk); sample_en = 0;
    ticks(cur_div - 1);
  endtask

  task automatic rd();
    @(negedge clk); data_rd = 1;
    if (mq.size() != 0) void'(mq.pop_front());
    @(negedge clk); data_rd = 0;
  endtask

  task automatic eclr();
    @(negedge clk); err_reset = 1; m_ovr = 0; m_brk = 0;
    @(negedge clk); err_reset = 0;
  endtask

  task automatic send(logic [7:0] d, bit pflip, bit slow, bit accept);
    logic [7:0] md;
    logic pb;
    md = d & ((8'd1 << cur_n) - 8'd1);
    cmp_en = 0;
    bitx(0);
    for (int i = 0; i < cur_n; i++) bitx(d[i]);
    pb = (cur_even ? ^md : ~^md) ^ pflip;
    if (cur_pen) bitx(pb);
    for (int s = 0; s < cur_stop; s++) bitx((slow && s == cur_stop - 1) ? 1'b0 : 1'b1);
    if (accept) begin
      logic [9:0] e;
      e = {pflip & cur_pen, slow, md};
      if (mq.size() == 3) begin mq[2] = e; m_ovr = 1; end
      else mq.push_back(e);
      if (slow && md == 0 && !(cur_pen && pb)) m_brk = 1;
    end
    cmp_en = 1;
    bitx(1); bitx(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 errors", err_byte, 8'h00);
    chk("R1 data", rx_data, 8'h00);
    cmp_en = 1;

    wr_mode(8'h44);
    wr_cfg(8'hC0);
    send(8'hA5, 0, 0, 0);
    chk("R2 disabled", status, 8'h00);

    wr_cfg(8'hC1);
    send(8'hA5, 0, 0, 1);
    chk("R4 x16 data", rx_data, 8'hA5);
    rd();
    @(negedge clk);
    chk("R8 empty after read", status, 8'h00);

    wr_cfg(8'h01); send(8'hF5, 0, 0, 1);
    chk("R3 five bits", rx_data, 8'h15); rd();
    wr_cfg(8'h81); send(8'hEB, 0, 0, 1);
    chk("R3 six bits", rx_data, 8'h2B); rd();
    wr_cfg(8'h41); send(8'hDA, 0, 0, 1);
    chk("R3 seven bits", rx_data, 8'h5A); rd();
    wr_cfg(8'hC1);

    wr_mode(8'h04); send(8'h3C, 0, 0, 1);
    chk("R4 x1", rx_data, 8'h3C); rd();
    wr_mode(8'h84); send(8'hC3, 0, 0, 1);
    chk("R4 x32", rx_data, 8'hC3); rd();
    wr_mode(8'hC4); send(8'h69, 0, 0, 1);
    chk("R4 x64", rx_data, 8'h69); rd();

    wr_mode(8'h44);
    cmp_en = 0;
    @(negedge clk); rxd = 0;
    ticks(4);
    @(negedge clk); rxd = 1;
    ticks(30);
    cmp_en = 1;
    @(negedge clk);
    chk("R5 false start", status, 8'h00);
    send(8'h5E, 0, 0, 1);
    chk("R5 after glitch", rx_data, 8'h5E); rd();

    wr_mode(8'h47);
    send(8'h96, 0, 0, 1);
    send(8'h96, 1, 0, 1);
    chk("R6 even good", err_byte, 8'h00);
    rd(); @(negedge clk);
    chk("R9 head advances", err_byte, 8'h10);
    rd();
    wr_mode(8'h45);
    send(8'h07, 0, 0, 1);
    chk("R6 odd good", err_byte, 8'h00); rd();
    send(8'h07, 1, 0, 1);
    chk("R6 odd bad", err_byte, 8'h10); rd();

    wr_mode(8'h4C);
    send(8'h81, 0, 0, 1);
    chk("R7 two stop good", err_byte, 8'h00); rd();
    send(8'h81, 0, 1, 1);
    chk("R7 second stop low", err_byte, 8'h40); rd();
    wr_mode(8'h44);
    send(8'h42, 0, 1, 1);
    chk("R7 one stop low", err_byte, 8'h40); rd();

    rd(); @(negedge clk);
    chk("R8 read on empty", status, 8'h00);

    send(8'h11, 0, 0, 1);
    send(8'h22, 0, 0, 1);
    send(8'h33, 0, 0, 1);
    chk("R8 three held", status, 8'h01);
    send(8'h44, 0, 0, 1);
    chk("R10 overrun", err_byte, 8'h20);
    rd(); rd(); @(negedge clk);
    chk("R10 newest replaced", rx_data, 8'h44);
    rd(); @(negedge clk);
    chk("R10 sticky after reads", err_byte, 8'h20);
    eclr(); @(negedge clk);
    chk("R10 cleared", err_byte, 8'h00);

    send(8'h00, 0, 1, 1);
    chk("R11 break", status, 8'h81);
    chk("R11 framing", err_byte, 8'h40);
    rd(); @(negedge clk);
    chk("R11 sticky", status, 8'h80);
    send(8'h77, 0, 0, 1);
    chk("R11 next char", rx_data, 8'h77); rd();
    eclr(); @(negedge clk);
    chk("R11 cleared", status, 8'h00);

    wr_cfg(8'hE1);
    dcd = 0;
    send(8'h3A, 0, 0, 0);
    chk("R2 carrier low", status, 8'h00);
    dcd = 1;
    send(8'h3A, 0, 0, 1);
    chk("R2 carrier high", rx_data, 8'h3A); rd();

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule